// File: doc/BRIEF.md
# Serial-Loaded Bank Mapper Registers

This block is the write side of a cartridge bank mapper whose four control registers cannot be written in parallel. Instead the CPU loads them one bit at a time. Each qualified write to the upper address range contributes data bit 0 to a 5-bit shift buffer. On the fifth write the gathered value moves into the register that the fifth write's address selects, and the buffer empties itself. Any write with data bit 7 set discards a partial value and restarts the sequence.

The four registers hold a control word, two CHR bank numbers and a PRG bank number. The block decodes them, together with the CPU address bit 14 and the video address bit 12, into the high PRG address lines (16 KB granularity) and the high CHR address lines (4 KB granularity). The clock is the CPU bus clock, so a write is taken on its rising edge. The outputs move only when a register transfer completes, or when the CPU or video address input that feeds them changes.

Top module: `serial_bank_mapper`

## Requirements
- R1: After reset the control register is 5'b01100, and the CHR and PRG bank registers are zero. With cpu_addr[14]=0, prg_bank_hi is 0. With cpu_addr[14]=1, prg_bank_hi is 4'hF. chr_bank_hi equals {4'b0000, ppu_a12}.
- R2: A qualified write whose cpu_data[7] is 1 empties the shift buffer and sets the write count to zero at once. The next value is then gathered from the five writes that follow it.
- R3: Each qualified write with cpu_data[7]=0 shifts cpu_data[0] into the buffer, least significant bit first. Five such writes form a 5-bit value, and the first of the five supplies bit 0.
- R4: Only the address of the fifth write picks the target register, through cpu_addr[14:13]: 0 is control, 1 is CHR bank 0, 2 is CHR bank 1 and 3 is PRG bank. The addresses of the first four writes have no effect.
- R5: After a transfer the buffer and count return to empty, so the sixth write begins a new value.
- R6: A write is taken only at a rising clock edge where both cpu_wr and prg_sel are 1. Edges where either is 0 leave the buffer and the count unchanged.
- R7: prg_bank_hi and chr_bank_hi change only when a transfer completes or when cpu_addr[14] or ppu_a12 changes. A partial shift never moves them.
- R8: Control bits [3:2] select the PRG mode, where P is the PRG bank register. Modes 0 and 1 give a 32 KB window {P[3:1], cpu_addr[14]}. Mode 2 fixes bank 0 at the low half and gives P at the high half. Mode 3 gives P at the low half and fixes bank 4'hF at the high half.
- R9: When control bit 4 is 0, chr_bank_hi selects a whole 8 KB bank, {CHR0[4:1], ppu_a12}. When control bit 4 is 1, it is CHR0 for ppu_a12=0 and CHR1 for ppu_a12=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock; writes are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cpu_wr | input | 1 | CPU write strobe, active high |
| prg_sel | input | 1 | PRG chip select, high for the upper CPU address range |
| cpu_addr | input | 15 | CPU address bits 14:0 |
| cpu_data | input | 8 | CPU write data |
| ppu_a12 | input | 1 | Video address bit 12 |
| prg_bank_hi | output | 4 | PRG address lines A14 to A17 |
| chr_bank_hi | output | 5 | CHR address lines A12 to A16 |

## Verification
The bank outputs show the shift buffer only indirectly. A wrong bit order, a miscounted write or a missed clear does not appear until the next fifth write, and it then shows as a wrong value in the addressed register. A partial shift that leaks into a register moves prg_bank_hi or chr_bank_hi in the cycle after that write. The bench therefore probes both output halves after every full load and after deliberately partial, gated and aborted sequences. The checker watches the write count cycle by cycle, so a count slip is caught at the edge where it happens.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_CHR0 = 2'd1,
      SEL_CHR1 = 2'd2,
      SEL_PRG  = 2'd3
   } sbm_sel_e;

   typedef enum logic [1:0] {
      PRG_WIDE_A    = 2'd0,
      PRG_WIDE_B    = 2'd1,
      PRG_FIX_LOW   = 2'd2,
      PRG_FIX_HIGH  = 2'd3
   } sbm_prg_mode_e;

   typedef struct packed {
      logic          chr_split;
      sbm_prg_mode_e prg_mode;
      logic [1:0]    aux;
   } sbm_ctrl_t;

   localparam int SBM_CTRL_W = $bits(sbm_ctrl_t);

endpackage

// File: rtl/sbm_shift_loader.sv
module sbm_shift_loader #(
   parameter int SHIFT_W = 5,
   parameter int CNT_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_fire,
   input  logic               din_bit,
   input  logic               din_clear,
   output logic               load_fire,
   output logic [SHIFT_W-1:0] load_val,
   output logic [CNT_W-1:0]   cnt
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SHIFT_W - 1);

   logic [SHIFT_W-1:0] buf_q;
   logic               at_last;

   assign at_last   = (cnt == LAST);
   assign load_fire = wr_fire & ~din_clear & at_last;
   assign load_val  = {din_bit, buf_q[SHIFT_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         cnt   <= '0;
      end else if (wr_fire) begin
         if (din_clear || at_last) begin
            buf_q <= '0;
            cnt   <= '0;
         end else begin
            buf_q <= {din_bit, buf_q[SHIFT_W-1:1]};
            cnt   <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sbm_reg_file.sv
module sbm_reg_file #(
   parameter int                REG_W    = 5,
   parameter int                NUM_REGS = 4,
   parameter int                SEL_W    = 2,
   parameter logic [REG_W-1:0]  CTRL_RST = '0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              load_fire,
   input  logic [SEL_W-1:0]                  load_sel,
   input  logic [REG_W-1:0]                  load_val,
   output logic [NUM_REGS-1:0][REG_W-1:0]    regs_q
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [REG_W-1:0] RST_V = (g == 0) ? CTRL_RST : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[g] <= RST_V;
         end else if (load_fire && (load_sel == SEL_W'(g))) begin
            regs_q[g] <= load_val;
         end
      end
   end

endmodule

// File: rtl/sbm_bank_decode.sv
module sbm_bank_decode
   import sbm_pkg::*;
#(
   parameter int REG_W        = 5,
   parameter int PRG_OUT_W    = 4,
   parameter int CHR_OUT_W    = 5,
   parameter bit CHR_SPLIT_EN = 1'b1
) (
   input  logic [REG_W-1:0]     ctrl_raw,
   input  logic [REG_W-1:0]     chr0_q,
   input  logic [REG_W-1:0]     chr1_q,
   input  logic [REG_W-1:0]     prg_q,
   input  logic                 cpu_a14,
   input  logic                 ppu_a12,
   output logic [PRG_OUT_W-1:0] prg_bank_hi,
   output logic [CHR_OUT_W-1:0] chr_bank_hi
);
   sbm_ctrl_t              ctrl;
   logic [PRG_OUT_W-1:0]   prg_sel_bank;
   logic [CHR_OUT_W-1:0]   chr_whole;
   logic                   unused_prg_hi;

   assign ctrl          = sbm_ctrl_t'(ctrl_raw[SBM_CTRL_W-1:0]);
   assign prg_sel_bank  = prg_q[PRG_OUT_W-1:0];
   assign chr_whole     = {chr0_q[CHR_OUT_W-1:1], ppu_a12};
   assign unused_prg_hi = ^{prg_q, ctrl.aux, chr0_q[0]};

   always_comb begin
      unique case (ctrl.prg_mode)
         PRG_FIX_LOW:  prg_bank_hi = cpu_a14 ? prg_sel_bank : '0;
         PRG_FIX_HIGH: prg_bank_hi = cpu_a14 ? '1 : prg_sel_bank;
         default:      prg_bank_hi = {prg_sel_bank[PRG_OUT_W-1:1], cpu_a14};
      endcase
   end

   if (CHR_SPLIT_EN) begin : g_chr_split
      always_comb begin
         if (ctrl.chr_split) begin
            chr_bank_hi = ppu_a12 ? chr1_q[CHR_OUT_W-1:0] : chr0_q[CHR_OUT_W-1:0];
         end else begin
            chr_bank_hi = chr_whole;
         end
      end
   end else begin : g_chr_whole
      logic unused_chr1;
      assign unused_chr1 = ^{chr1_q, ctrl.chr_split};
      assign chr_bank_hi = chr_whole;
   end

endmodule

// File: rtl/serial_bank_mapper.sv
module serial_bank_mapper
   import sbm_pkg::*;
#(
   parameter int               ADDR_W       = 15,
   parameter int               SEL_LSB      = 13,
   parameter int               SHIFT_W      = 5,
   parameter int               PRG_OUT_W    = 4,
   parameter int               CHR_OUT_W    = 5,
   parameter bit               CHR_SPLIT_EN = 1'b1,
   parameter logic [SHIFT_W-1:0] CTRL_RESET = 5'b01100
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cpu_wr,
   input  logic                 prg_sel,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic [7:0]           cpu_data,
   input  logic                 ppu_a12,
   output logic [PRG_OUT_W-1:0] prg_bank_hi,
   output logic [CHR_OUT_W-1:0] chr_bank_hi
);
   localparam int NUM_REGS = 4;
   localparam int SEL_W    = $clog2(NUM_REGS);
   localparam int CNT_W    = $clog2(SHIFT_W + 1);

   if (SHIFT_W < SBM_CTRL_W) begin : g_bad_shift
      $error("SHIFT_W must cover the control word");
   end
   if (SEL_LSB + SEL_W > ADDR_W) begin : g_bad_sel
      $error("register select bits exceed the address width");
   end
   if (PRG_OUT_W < 2 || PRG_OUT_W > SHIFT_W) begin : g_bad_prg
      $error("PRG_OUT_W must lie in 2..SHIFT_W");
   end
   if (CHR_OUT_W < 2 || CHR_OUT_W > SHIFT_W) begin : g_bad_chr
      $error("CHR_OUT_W must lie in 2..SHIFT_W");
   end

   logic                          wr_fire;
   logic                          load_fire;
   logic [SHIFT_W-1:0]            load_val;
   logic [CNT_W-1:0]              shift_cnt;
   logic [NUM_REGS-1:0][SHIFT_W-1:0] regs_q;
   logic                          unused_bus;

   assign wr_fire    = cpu_wr & prg_sel;
   assign unused_bus = ^{cpu_data[6:1], cpu_addr};

   sbm_shift_loader #(
      .SHIFT_W (SHIFT_W),
      .CNT_W   (CNT_W)
   ) u_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_fire   (wr_fire),
      .din_bit   (cpu_data[0]),
      .din_clear (cpu_data[7]),
      .load_fire (load_fire),
      .load_val  (load_val),
      .cnt       (shift_cnt)
   );

   sbm_reg_file #(
      .REG_W    (SHIFT_W),
      .NUM_REGS (NUM_REGS),
      .SEL_W    (SEL_W),
      .CTRL_RST (CTRL_RESET)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_fire (load_fire),
      .load_sel  (cpu_addr[SEL_LSB +: SEL_W]),
      .load_val  (load_val),
      .regs_q    (regs_q)
   );

   sbm_bank_decode #(
      .REG_W        (SHIFT_W),
      .PRG_OUT_W    (PRG_OUT_W),
      .CHR_OUT_W    (CHR_OUT_W),
      .CHR_SPLIT_EN (CHR_SPLIT_EN)
   ) u_decode (
      .ctrl_raw    (regs_q[SEL_CTRL]),
      .chr0_q      (regs_q[SEL_CHR0]),
      .chr1_q      (regs_q[SEL_CHR1]),
      .prg_q       (regs_q[SEL_PRG]),
      .cpu_a14     (cpu_addr[ADDR_W-1]),
      .ppu_a12     (ppu_a12),
      .prg_bank_hi (prg_bank_hi),
      .chr_bank_hi (chr_bank_hi)
   );

endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
   parameter int ADDR_W    = 15,
   parameter int SHIFT_W   = 5,
   parameter int CNT_W     = 3,
   parameter int PRG_OUT_W = 4,
   parameter int CHR_OUT_W = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cpu_wr,
   input logic                 prg_sel,
   input logic [ADDR_W-1:0]    cpu_addr,
   input logic [7:0]           cpu_data,
   input logic                 ppu_a12,
   input logic [PRG_OUT_W-1:0] prg_bank_hi,
   input logic [CHR_OUT_W-1:0] chr_bank_hi,
   input logic [CNT_W-1:0]     shift_cnt,
   input logic                 load_fire
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SHIFT_W - 1);

   logic taken;
   assign taken = cpu_wr & prg_sel;

   a_r2_bit7_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && cpu_data[7]) |=> (shift_cnt == '0));

   a_r3_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && !cpu_data[7] && shift_cnt != LAST) |=> (shift_cnt == $past(shift_cnt) + 1'b1));

   a_r5_restart_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_fire |=> (shift_cnt == '0));

   a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      shift_cnt <= LAST);

   a_r6_idle_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |=> $stable(shift_cnt));

   a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load_fire |=> (!($stable(cpu_addr[ADDR_W-1]) && $stable(ppu_a12))
                      || ($stable(prg_bank_hi) && $stable(chr_bank_hi))));

endmodule

bind serial_bank_mapper sbm_checker #(
   .ADDR_W    (ADDR_W),
   .SHIFT_W   (SHIFT_W),
   .CNT_W     (CNT_W),
   .PRG_OUT_W (PRG_OUT_W),
   .CHR_OUT_W (CHR_OUT_W)
) u_sbm_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_wr      (cpu_wr),
   .prg_sel     (prg_sel),
   .cpu_addr    (cpu_addr),
   .cpu_data    (cpu_data),
   .ppu_a12     (ppu_a12),
   .prg_bank_hi (prg_bank_hi),
   .chr_bank_hi (chr_bank_hi),
   .shift_cnt   (shift_cnt),
   .load_fire   (load_fire)
);

// File: tb/serial_bank_mapper_bench.sv
module serial_bank_mapper_bench;

   typedef struct {
      string      tag;
      logic [3:0] eprg;
      logic [4:0] echr;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr = 1'b0;
   logic        prg_sel = 1'b0;
   logic [14:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic        ppu_a12 = 1'b0;
   logic [3:0]  prg_bank_hi;
   logic [4:0]  chr_bank_hi;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;
   item_t sb_q[$];

   logic [4:0] m_ctrl = 5'b01100;
   logic [4:0] m_chr0 = '0;
   logic [4:0] m_chr1 = '0;
   logic [4:0] m_prg  = '0;

   always #4 clk = ~clk;

   serial_bank_mapper u_serial_bank_mapper (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_wr      (cpu_wr),
      .prg_sel     (prg_sel),
      .cpu_addr    (cpu_addr),
      .cpu_data    (cpu_data),
      .ppu_a12     (ppu_a12),
      .prg_bank_hi (prg_bank_hi),
      .chr_bank_hi (chr_bank_hi)
   );

   function automatic logic [3:0] exp_prg(input logic a14);
      case (m_ctrl[3:2])
         2'd2:    return a14 ? m_prg[3:0] : 4'h0;
         2'd3:    return a14 ? 4'hF : m_prg[3:0];
         default: return {m_prg[3:1], a14};
      endcase
   endfunction

   function automatic logic [4:0] exp_chr(input logic a12);
      if (m_ctrl[4]) return a12 ? m_chr1 : m_chr0;
      return {m_chr0[4:1], a12};
   endfunction

   // monitor: compares one queued item per cycle, away from the edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (prg_bank_hi !== it.eprg || chr_bank_hi !== it.echr) begin
               n_fail++;
               $display("FAIL %s: prg=%h chr=%h expected prg=%h chr=%h",
                        it.tag, prg_bank_hi, chr_bank_hi, it.eprg, it.echr);
            end
         end
      end
   end

   // called at a negedge; sets probe inputs and queues the expectation
   task automatic probe(input string tag, input logic a14, input logic a12);
      item_t it;
      cpu_wr      = 1'b0;
      cpu_addr[14] = a14;
      ppu_a12     = a12;
      it.tag  = tag;
      it.eprg = exp_prg(a14);
      it.echr = exp_chr(a12);
      sb_q.push_back(it);
      @(negedge clk);
   endtask

   task automatic probe_all(input string tag);
      probe(tag, 1'b0, 1'b0);
      probe(tag, 1'b1, 1'b1);
      probe(tag, 1'b0, 1'b1);
      probe(tag, 1'b1, 1'b0);
   endtask

   task automatic bus_write(input logic [1:0] sel, input logic [7:0] d,
                            input logic wr, input logic ps);
      cpu_addr = {sel, 13'h0A5A};
      cpu_data = d;
      cpu_wr   = wr;
      prg_sel  = ps;
      @(negedge clk);
      cpu_wr   = 1'b0;
      prg_sel  = 1'b0;
   endtask

   // five writes; the first four use the complement of the target select
   task automatic load(input logic [1:0] sel, input logic [4:0] v);
      for (int i = 0; i < 5; i++) begin
         bus_write((i == 4) ? sel : ~sel, {7'b0110100, v[i]}, 1'b1, 1'b1);
      end
      case (sel)
         2'd0: m_ctrl = v;
         2'd1: m_chr0 = v;
         2'd2: m_chr1 = v;
         default: m_prg = v;
      endcase
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      probe_all("R1 reset state");

      load(2'd3, 5'h06);
      probe_all("R4 R8 PRG load mode 3");

      // R7: three partial writes must not move outputs
      bus_write(2'd1, 8'h01, 1'b1, 1'b1);
      bus_write(2'd1, 8'h00, 1'b1, 1'b1);
      bus_write(2'd1, 8'h01, 1'b1, 1'b1);
      probe_all("R7 partial shift holds outputs");

      // R2: abort the partial value, then a clean load
      bus_write(2'd1, 8'h81, 1'b1, 1'b1);
      load(2'd1, 5'h0B);
      probe_all("R2 R3 clear then CHR0 load");

      load(2'd2, 5'h13);
      probe_all("R9 CHR1 load in 8KB mode");

      load(2'd0, 5'b11100);
      probe_all("R9 split CHR mode");

      load(2'd0, 5'b11000);
      probe_all("R8 fixed low PRG mode");

      load(2'd0, 5'b10000);
      probe_all("R8 32KB PRG mode");

      // R6: gated writes interleaved must be ignored
      bus_write(2'd0, 8'h01, 1'b1, 1'b1);
      bus_write(2'd3, 8'h01, 1'b1, 1'b0);
      bus_write(2'd3, 8'h81, 1'b0, 1'b1);
      bus_write(2'd0, 8'h00, 1'b1, 1'b1);
      bus_write(2'd0, 8'h00, 1'b1, 1'b1);
      bus_write(2'd3, 8'h81, 1'b0, 1'b0);
      bus_write(2'd0, 8'h01, 1'b1, 1'b1);
      bus_write(2'd3, 8'h00, 1'b1, 1'b1);
      m_prg = 5'h09;
      probe_all("R6 gated writes ignored");

      // R5: back-to-back loads with no gap
      load(2'd3, 5'h0C);
      load(2'd3, 5'h03);
      probe_all("R5 sixth write starts new value");

      load(2'd3, 5'h0C);
      probe_all("R5 R3 reload after back-to-back");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule